// File: doc/BRIEF.md
# I/O MMU Control and Fault Register Bank

This block is the register file that software uses to steer an I/O address translation unit. It decodes a plain single-cycle write bus and a combinational read port. From them it keeps the translation mode, a configuration word and the page-table root pointer. It turns TLB maintenance writes into one-cycle pulses toward the translation engine. It also records faults that the engine reports.

A reported fault does four things: it sets a pending bit for its fault class, latches the faulting address into that class's own capture register, raises the interrupt line and parks the translation path in the held (blocked) mode. Software then inspects the capture registers and acknowledges each class through a write-one-to-clear register. Translation restarts only when software writes the run code to the control register again. The held mode comes with a handshake: a status bit tells software that the engine has gone quiet.

Top module: `iommu_ctrl_regs`

## Requirements
- R1: After reset the mode is off: `xlat_en` and `xlat_block` are 0, the control register reads 0, `irq` is 0, interrupt status reads 0 and both flush pulses are 0.
- R2: A write to the control register (offset 0x000) of 0x5 selects run mode (`xlat_en`=1, `xlat_block`=0). A write of 0x7 selects held mode (`xlat_en`=1, `xlat_block`=1). A write of 0x0 selects off (`xlat_en`=0, `xlat_block`=0). Any other value leaves the mode unchanged. The register reads back the code of the current mode.
- R3: Status register (offset 0x008) bit 0 reads 1 exactly when the mode is held and `eng_idle` is 1.
- R4: Writing the flush-all register (offset 0x00C) with bit 0 set raises `flush_all` for exactly the one cycle that follows the write edge. With bit 0 clear, the write produces no pulse.
- R5: Writing the flush-entry register (offset 0x010) with bit 0 set raises `flush_entry` for one cycle, with `flush_vpn` equal to write data bits [31:12]. With bit 0 clear, the write produces no pulse.
- R6: Writing the page-table base register (offset 0x014) updates `pt_base` and its read-back value, and also produces a one-cycle `flush_all` pulse.
- R7: When the mode is not off, a fault of class n (`flt_valid` with `flt_type`=n) sets interrupt status bit n and forces held mode. If bit n was clear, it also stores `flt_addr` in capture register n at offset 0x024+4n (class 0 at 0x024 up to class 3 at 0x030). A later fault of the same class leaves the capture unchanged while bit n is pending. A fault that arrives while the mode is off is ignored.
- R8: `irq` is 1 whenever any interrupt status bit (offset 0x018, bit n for class n) is set.
- R9: Writing the clear register (offset 0x01C) clears every interrupt status bit that has a 1 at the same position in the write data. A fault of a class arriving in the same cycle as the clear of that class leaves the bit set.
- R10: Status register bits [9:8] hold the index of the lowest pending fault class, and read 0 when no fault is pending.
- R11: The configuration register (offset 0x004) reads back the written value ANDed with the write mask 0x0150FFFF and drives `cfg_bits`. Offset 0x034 reads the fixed version word 0x00010003.
- R12: A read of an offset with no register behind it returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| eng_idle | input | 1 | Engine reports no translation in flight |
| flt_valid | input | 1 | Fault report strobe from the engine |
| flt_type | input | 2 | Fault class of the report |
| flt_addr | input | 32 | Faulting address |
| xlat_en | output | 1 | Translation path enabled |
| xlat_block | output | 1 | Translation path asked to hold |
| flush_all | output | 1 | One-cycle request to drop all TLB entries |
| flush_entry | output | 1 | One-cycle request to drop one TLB entry |
| flush_vpn | output | 20 | Page number for `flush_entry` |
| pt_base | output | 32 | Page-table root pointer |
| cfg_bits | output | 32 | Masked configuration word |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a fault report that lands in the very cycle in which software clears the same class. It depends on two independent agents lining up on one edge. The bench drives the clear write and the fault strobe from the same negative edge, and then checks that the pending bit survives. A second hard case is a repeat fault on a class that is still pending. The bench produces it by reporting two faults of one class back to back with different addresses, and then reads the capture register to confirm it holds the first address.

// File: rtl/iommu_regs_pkg.sv
package iommu_regs_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_RUN  = 2'd1,
        MODE_HOLD = 2'd2
    } mode_e;

    localparam logic [31:0] CODE_OFF  = 32'h0000_0000;
    localparam logic [31:0] CODE_RUN  = 32'h0000_0005;
    localparam logic [31:0] CODE_HOLD = 32'h0000_0007;

    localparam int OFF_CTRL  = 'h000;
    localparam int OFF_CFG   = 'h004;
    localparam int OFF_STAT  = 'h008;
    localparam int OFF_FALL  = 'h00C;
    localparam int OFF_FENT  = 'h010;
    localparam int OFF_PTB   = 'h014;
    localparam int OFF_ISTAT = 'h018;
    localparam int OFF_ICLR  = 'h01C;
    localparam int OFF_CAP0  = 'h024;
    localparam int OFF_VER   = 'h034;

    localparam int VPN_LSB   = 12;
    localparam int VPN_W     = 32 - VPN_LSB;
    localparam int PRIM_LSB  = 8;

    function automatic logic [31:0] mode_code(input mode_e m);
        case (m)
            MODE_RUN:  return CODE_RUN;
            MODE_HOLD: return CODE_HOLD;
            default:   return CODE_OFF;
        endcase
    endfunction

    function automatic int unsigned lowest_set(input logic [31:0] v);
        int unsigned r;
        r = 0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/iommu_mode_ctl.sv
module iommu_mode_ctl
    import iommu_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctl_wr,
    input  logic [31:0] ctl_data,
    input  logic        fault_hit,
    input  logic        eng_idle,
    output mode_e       mode,
    output logic        blk_ack
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_OFF;
        end else if (fault_hit) begin
            mode <= MODE_HOLD;
        end else if (ctl_wr) begin
            case (ctl_data)
                CODE_OFF:  mode <= MODE_OFF;
                CODE_RUN:  mode <= MODE_RUN;
                CODE_HOLD: mode <= MODE_HOLD;
                default:   mode <= mode;
            endcase
        end
    end

    always_comb blk_ack = (mode == MODE_HOLD) && eng_idle;

    // R7: an accepted fault always parks the path in held mode
    a_r7_fault_holds: assert property (@(posedge clk) disable iff (rst)
        fault_hit |=> mode == MODE_HOLD);

    // R2: unknown codes leave the mode alone
    a_r2_bad_code_keeps: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !fault_hit && ctl_data != CODE_OFF && ctl_data != CODE_RUN
         && ctl_data != CODE_HOLD) |=> $stable(mode));

endmodule

// File: rtl/iommu_fault_bank.sv
module iommu_fault_bank #(
    parameter int NFAULT = 4,
    parameter int AW     = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NFAULT-1:0]          set_vec,
    input  logic [NFAULT-1:0]          clr_vec,
    input  logic [AW-1:0]              flt_addr,
    output logic [NFAULT-1:0]          pend,
    output logic [NFAULT-1:0][AW-1:0]  cap
);

    for (genvar n = 0; n < NFAULT; n++) begin : g_cls
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[n] <= 1'b0;
                cap[n]  <= '0;
            end else begin
                if (set_vec[n] && !pend[n]) cap[n] <= flt_addr;
                if (set_vec[n])             pend[n] <= 1'b1;
                else if (clr_vec[n])        pend[n] <= 1'b0;
            end
        end

        // R9: a clear without a competing fault drops the bit
        a_r9_clear_drops: assert property (@(posedge clk) disable iff (rst)
            (clr_vec[n] && !set_vec[n]) |=> !pend[n]);

        // R9: a fault beats a clear of the same class
        a_r9_fault_wins: assert property (@(posedge clk) disable iff (rst)
            set_vec[n] |=> pend[n]);

        // R7: the first address is kept while the class is pending
        a_r7_capture_kept: assert property (@(posedge clk) disable iff (rst)
            (pend[n] && !clr_vec[n]) |=> $stable(cap[n]));
    end

endmodule

// File: rtl/iommu_flush_gen.sv
module iommu_flush_gen
    import iommu_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             all_req,
    input  logic             ent_req,
    input  logic [31:0]      ent_data,
    output logic             flush_all,
    output logic             flush_entry,
    output logic [VPN_W-1:0] flush_vpn
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flush_all   <= 1'b0;
            flush_entry <= 1'b0;
            flush_vpn   <= '0;
        end else begin
            flush_all   <= all_req;
            flush_entry <= ent_req;
            if (ent_req) flush_vpn <= ent_data[31:VPN_LSB];
        end
    end

    // R4: a flush-all pulse lasts one cycle unless re-requested
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (flush_all && !all_req) |=> !flush_all);

    // R5: the page number only moves on an entry request
    a_r5_vpn_hold: assert property (@(posedge clk) disable iff (rst)
        !ent_req |=> $stable(flush_vpn));

endmodule

// File: rtl/iommu_ctrl_regs.sv
module iommu_ctrl_regs
    import iommu_regs_pkg::*;
#(
    parameter int          NFAULT   = 4,
    parameter int          ADDR_W   = 8,
    parameter logic [31:0] CFG_MASK = 32'h0150_FFFF,
    parameter logic [31:0] VERSION  = 32'h0001_0003
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic                      eng_idle,
    input  logic                      flt_valid,
    input  logic [$clog2(NFAULT)-1:0] flt_type,
    input  logic [31:0]               flt_addr,
    output logic                      xlat_en,
    output logic                      xlat_block,
    output logic                      flush_all,
    output logic                      flush_entry,
    output logic [VPN_W-1:0]          flush_vpn,
    output logic [31:0]               pt_base,
    output logic [31:0]               cfg_bits,
    output logic                      irq
);

    localparam int FT_W = $clog2(NFAULT);

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
        return a == ADDR_W'(off);
    endfunction

    mode_e                    mode;
    logic                     blk_ack;
    logic                     flt_ok;
    logic [NFAULT-1:0]        set_vec;
    logic [NFAULT-1:0]        clr_vec;
    logic [NFAULT-1:0]        pend;
    logic [NFAULT-1:0][31:0]  cap;
    logic [FT_W-1:0]          primary;
    logic                     wr_ctrl, wr_cfg, wr_fall, wr_fent, wr_ptb, wr_clr;

    always_comb begin
        wr_ctrl = bus_wr && hit(bus_addr, OFF_CTRL);
        wr_cfg  = bus_wr && hit(bus_addr, OFF_CFG);
        wr_fall = bus_wr && hit(bus_addr, OFF_FALL);
        wr_fent = bus_wr && hit(bus_addr, OFF_FENT);
        wr_ptb  = bus_wr && hit(bus_addr, OFF_PTB);
        wr_clr  = bus_wr && hit(bus_addr, OFF_ICLR);
    end

    always_comb begin
        flt_ok  = flt_valid && (mode != MODE_OFF) && (32'(flt_type) < NFAULT);
        set_vec = '0;
        if (flt_ok) set_vec[flt_type] = 1'b1;
        clr_vec = wr_clr ? bus_wdata[NFAULT-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pt_base  <= '0;
            cfg_bits <= '0;
        end else begin
            if (wr_ptb) pt_base  <= bus_wdata;
            if (wr_cfg) cfg_bits <= bus_wdata & CFG_MASK;
        end
    end

    iommu_mode_ctl u_mode (
        .clk       (clk),
        .rst       (rst),
        .ctl_wr    (wr_ctrl),
        .ctl_data  (bus_wdata),
        .fault_hit (flt_ok),
        .eng_idle  (eng_idle),
        .mode      (mode),
        .blk_ack   (blk_ack)
    );

    iommu_fault_bank #(.NFAULT(NFAULT), .AW(32)) u_faults (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .flt_addr (flt_addr),
        .pend     (pend),
        .cap      (cap)
    );

    iommu_flush_gen u_flush (
        .clk         (clk),
        .rst         (rst),
        .all_req     ((wr_fall && bus_wdata[0]) || wr_ptb),
        .ent_req     (wr_fent && bus_wdata[0]),
        .ent_data    (bus_wdata),
        .flush_all   (flush_all),
        .flush_entry (flush_entry),
        .flush_vpn   (flush_vpn)
    );

    always_comb begin
        xlat_en    = (mode != MODE_OFF);
        xlat_block = (mode == MODE_HOLD);
        irq        = |pend;
        primary    = FT_W'(lowest_set(32'(pend)));
    end

    always_comb begin
        bus_rdata = '0;
        if (hit(bus_addr, OFF_CTRL))  bus_rdata = mode_code(mode);
        if (hit(bus_addr, OFF_CFG))   bus_rdata = cfg_bits;
        if (hit(bus_addr, OFF_STAT)) begin
            bus_rdata[0]                    = blk_ack;
            bus_rdata[PRIM_LSB +: FT_W]     = primary;
        end
        if (hit(bus_addr, OFF_PTB))   bus_rdata = pt_base;
        if (hit(bus_addr, OFF_ISTAT)) bus_rdata = 32'(pend);
        if (hit(bus_addr, OFF_VER))   bus_rdata = VERSION;
        for (int n = 0; n < NFAULT; n++) begin
            if (hit(bus_addr, OFF_CAP0 + 4 * n)) bus_rdata = cap[n];
        end
    end

    // R8: an accepted fault raises the interrupt on the next cycle
    a_r8_irq_follows: assert property (@(posedge clk) disable iff (rst)
        flt_ok |=> irq);

    // R6: a base write is followed by a flush-all pulse
    a_r6_base_flushes: assert property (@(posedge clk) disable iff (rst)
        wr_ptb |=> flush_all);

    // R7: faults are not taken while translation is off
    a_r7_off_ignores: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_OFF && !wr_ctrl && !wr_clr) |=> $stable(pend));

endmodule

// File: tb/iommu_ctrl_regs_bench.sv
module iommu_ctrl_regs_bench;

    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        eng_idle;
    logic        flt_valid;
    logic [1:0]  flt_type;
    logic [31:0] flt_addr;
    logic        xlat_en, xlat_block, flush_all, flush_entry, irq;
    logic [19:0] flush_vpn;
    logic [31:0] pt_base, cfg_bits;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    iommu_ctrl_regs u_iommu_ctrl_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_idle(eng_idle),
        .flt_valid(flt_valid), .flt_type(flt_type), .flt_addr(flt_addr),
        .xlat_en(xlat_en), .xlat_block(xlat_block), .flush_all(flush_all),
        .flush_entry(flush_entry), .flush_vpn(flush_vpn), .pt_base(pt_base),
        .cfg_bits(cfg_bits), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at a negedge, the write lands on the next posedge; returns at the
    // following negedge where registered outputs show the result
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic fault(input logic [1:0] t, input logic [31:0] a);
        @(negedge clk);
        flt_valid = 1'b1; flt_type = t; flt_addr = a;
        @(negedge clk);
        flt_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h00, v); chk("R1 ctrl", v, 0);
        rd(8'h18, v); chk("R1 istat", v, 0);
        chk("R1 en/blk/irq/flush", {xlat_en, xlat_block, irq, flush_all, flush_entry}, 0);
        fault(2'd1, 32'hDEAD_0000);
        rd(8'h18, v); chk("R7 fault ignored while off", v, 0);
        chk("R7 no irq while off", irq, 0);
    endtask

    task automatic t_mode();
        logic [31:0] v;
        wr(8'h00, 32'h5);
        chk("R2 run en/blk", {xlat_en, xlat_block}, 2'b10);
        rd(8'h00, v); chk("R2 run code", v, 5);
        wr(8'h00, 32'h3);
        rd(8'h00, v); chk("R2 bad code ignored", v, 5);
        wr(8'h00, 32'h7);
        chk("R2 hold en/blk", {xlat_en, xlat_block}, 2'b11);
        eng_idle = 1'b0;
        rd(8'h08, v); chk("R3 no ack while busy", v[0], 0);
        eng_idle = 1'b1;
        rd(8'h08, v); chk("R3 ack when quiet", v[0], 1);
        wr(8'h00, 32'h0);
        chk("R2 off en/blk", {xlat_en, xlat_block}, 2'b00);
        rd(8'h08, v); chk("R3 no ack when off", v[0], 0);
    endtask

    task automatic t_flush();
        wr(8'h0C, 32'h1);
        chk("R4 pulse", flush_all, 1);
        @(negedge clk);
        chk("R4 pulse ends", flush_all, 0);
        wr(8'h0C, 32'h2);
        chk("R4 bit0 clear no pulse", flush_all, 0);
        wr(8'h10, 32'hABCD_E001);
        chk("R5 entry pulse", flush_entry, 1);
        chk("R5 vpn", flush_vpn, 20'hABCDE);
        @(negedge clk);
        chk("R5 pulse ends", flush_entry, 0);
        wr(8'h10, 32'h1234_5000);
        chk("R5 bit0 clear no pulse", flush_entry, 0);
        chk("R5 vpn kept", flush_vpn, 20'hABCDE);
    endtask

    task automatic t_ptbase();
        logic [31:0] v;
        wr(8'h14, 32'h8000_4000);
        chk("R6 flush on base", flush_all, 1);
        chk("R6 pt_base", pt_base, 32'h8000_4000);
        rd(8'h14, v); chk("R6 readback", v, 32'h8000_4000);
    endtask

    task automatic t_fault();
        logic [31:0] v;
        wr(8'h00, 32'h5);
        fault(2'd2, 32'h1111_2000);
        chk("R8 irq", irq, 1);
        chk("R7 hold after fault", xlat_block, 1);
        rd(8'h00, v); chk("R7 ctrl reads hold", v, 7);
        rd(8'h18, v); chk("R7 istat bit2", v, 32'h4);
        rd(8'h2C, v); chk("R7 capture class2", v, 32'h1111_2000);
        fault(2'd2, 32'h2222_3000);
        rd(8'h2C, v); chk("R7 first capture kept", v, 32'h1111_2000);
        fault(2'd3, 32'h3333_4000);
        rd(8'h18, v); chk("R7 istat two bits", v, 32'hC);
        rd(8'h30, v); chk("R7 capture class3", v, 32'h3333_4000);
        rd(8'h08, v); chk("R10 primary lowest", v[9:8], 2);
        wr(8'h1C, 32'h4);
        rd(8'h18, v); chk("R9 clear bit2", v, 32'h8);
        rd(8'h08, v); chk("R10 primary next", v[9:8], 3);
        // same-edge clear and fault of class 3
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h1C; bus_wdata = 32'h8;
        flt_valid = 1'b1; flt_type = 2'd3; flt_addr = 32'h4444_0000;
        @(negedge clk);
        bus_wr = 1'b0; flt_valid = 1'b0;
        rd(8'h18, v); chk("R9 fault wins over clear", v, 32'h8);
        chk("R8 irq still set", irq, 1);
        wr(8'h1C, 32'hF);
        chk("R8 irq drops", irq, 0);
        rd(8'h08, v); chk("R10 primary empty", v[9:8], 0);
        rd(8'h18, v); chk("R9 all clear", v, 0);
        wr(8'h00, 32'h5);
        chk("R2 resume run", {xlat_en, xlat_block}, 2'b10);
    endtask

    task automatic t_misc();
        logic [31:0] v;
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, v); chk("R11 cfg masked", v, 32'h0150_FFFF);
        chk("R11 cfg out", cfg_bits, 32'h0150_FFFF);
        rd(8'h34, v); chk("R11 version", v, 32'h0001_0003);
        rd(8'h40, v); chk("R12 unmapped", v, 0);
        rd(8'h20, v); chk("R12 hole", v, 0);
    endtask

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        eng_idle = 1'b1; flt_valid = 1'b0; flt_type = '0; flt_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mode();
        t_flush();
        t_ptbase();
        t_fault();
        t_misc();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule